// File: doc/BRIEF.md
# DDR SDRAM Power-Up Init Sequencer

This block brings a DDR SDRAM interface out of power-up once the controller has been configured. On a `start` request it checks the two slot page-size codes. If at least one slot is populated, it walks through the standard start-up order. It enables the clock-enable lines, then issues an extended mode register write with a precharge-all forced ahead of it, and a mode register write that resets the DLL. It then waits a fixed number of clocks for the DLL to settle. Next come two auto refreshes: the first has a forced precharge-all in front of it, and the second follows after a programmable gap. A last mode register write releases the DLL reset.

Every command strobe is a single-cycle pulse. The force-precharge qualifier is a level that the command path samples together with the strobe it qualifies. When the sequence ends, `done` rises and holds until `start` is removed. At that point the clock enable of the second slot is dropped if that slot is empty. If both slots are empty, the block raises `no_mem_err` instead and issues nothing.

States and transitions:

| State | Exit condition | Next state |
|---|---|---|
| S_IDLE | `start` high with both slots empty | S_NOMEM |
| S_IDLE | `start` high otherwise | S_CKE_ON |
| S_NOMEM | `start` low | S_IDLE |
| S_CKE_ON | always | S_PRE_A_SET |
| S_PRE_A_SET | always | S_EMRS |
| S_EMRS | always | S_PRE_A_CLR |
| S_PRE_A_CLR | always | S_MRS_RST |
| S_MRS_RST | always; loads the DLL wait into the timer | S_DLL_WAIT |
| S_DLL_WAIT | timer at zero | S_PRE_B_SET |
| S_PRE_B_SET | always | S_REF_A |
| S_REF_A | always; loads `ref_gap` into the timer | S_REF_GAP |
| S_REF_GAP | timer at zero | S_REF_B |
| S_REF_B | always | S_MRS_FIN |
| S_MRS_FIN | always | S_DONE |
| S_DONE | `start` low | S_IDLE |

Top module: `ddr_pwrup_seq`

## Requirements
- R1: After reset, and while `start` stays low, `cke_en`, `force_pre`, all four command strobes, `no_mem_err` and `done` are all 0.
- R2: A slot whose 3-bit page-size code equals 7 is empty. If `start` rises while both slots are empty, `no_mem_err` is 1 from the next cycle on. While it is 1, no strobe fires and `cke_en` is 0. It stays 1 while `start` is held and clears one cycle after `start` falls.
- R3: With at least one slot populated, the cycle after `start` is seen counts as cycle 1. The EMRS pulse fires in cycle 3 and the DLL-reset MRS in cycle 5. Then come the first and second refresh, and the final MRS fires the cycle after the second refresh. Each of these fires exactly once per run.
- R4: `force_pre` is 1 in the cycle before the EMRS pulse, in the EMRS cycle and in the first refresh cycle. It is 0 during both MRS pulses and during the second refresh.
- R5: Each strobe is high for one cycle only, and no two strobes are high in the same cycle.
- R6: The first refresh fires exactly DLL_WAIT_CLKS+3 cycles after the DLL-reset MRS (default DLL_WAIT_CLKS = 200).
- R7: The second refresh fires exactly `ref_gap`+2 cycles after the first refresh.
- R8: `cke_en` is 2'b11 from cycle 1 until `done` rises, and in particular whenever a strobe fires.
- R9: `done` rises one cycle after the final MRS and stays 1 while `start` is high. One cycle after `start` falls, `done` and `cke_en` are 0.
- R10: While `done` is 1, `cke_en[0]` is 1. `cke_en[1]` is 1 only if slot 1 was populated when the run started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Level request to run the sequence |
| slot0_psz | input | 3 | Page-size code of slot 0 (7 = empty) |
| slot1_psz | input | 3 | Page-size code of slot 1 (7 = empty) |
| ref_gap | input | GAP_W (8) | Extra clocks between the two refreshes |
| cke_en | output | 2 | Clock-enable per slot |
| force_pre | output | 1 | Precharge-all qualifier for the current command |
| cmd_emrs | output | 1 | Extended mode register write pulse |
| cmd_mrs_dll_rst | output | 1 | Mode register write pulse, DLL reset set |
| cmd_mrs_final | output | 1 | Mode register write pulse, DLL reset cleared |
| cmd_refresh | output | 1 | Auto refresh pulse |
| no_mem_err | output | 1 | Both slots empty |
| done | output | 1 | Sequence complete |

## Verification
The bench records the cycle of every strobe and measures spacings against the requirements. A timer that is off by one shows up as a DLL wait or refresh gap that is one cycle too short or too long. It also checks the qualifier at each strobe. A design that forgot to drop `force_pre` would precharge ahead of the second refresh or an MRS, and one that set it late would issue the EMRS with no precharge in front. Two edge cases are covered. A `ref_gap` of zero and of 255 tests the counter limits. Both-empty and single-empty slot mixes test the abort path and whether the empty second slot's clock enable is released at the end.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    localparam int PSZ_W      = 3;
    localparam int PSZ_EMPTY  = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_NOMEM,
        S_CKE_ON,
        S_PRE_A_SET,
        S_EMRS,
        S_PRE_A_CLR,
        S_MRS_RST,
        S_DLL_WAIT,
        S_PRE_B_SET,
        S_REF_A,
        S_REF_GAP,
        S_REF_B,
        S_MRS_FIN,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/ddr_slot_decode.sv
module ddr_slot_decode
    import ddr_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic [NUM_SLOTS*PSZ_W-1:0] psz_codes,
    output logic [NUM_SLOTS-1:0]       present
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign present[s] = (psz_codes[s*PSZ_W +: PSZ_W] != PSZ_W'(PSZ_EMPTY));
    end

endmodule

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_seq_pkg::*;
#(
    parameter int DLL_WAIT_CLKS = 200,
    parameter int GAP_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       slot0_psz,
    input  logic [2:0]       slot1_psz,
    input  logic [GAP_W-1:0] ref_gap,
    output logic [1:0]       cke_en,
    output logic             force_pre,
    output logic             cmd_emrs,
    output logic             cmd_mrs_dll_rst,
    output logic             cmd_mrs_final,
    output logic             cmd_refresh,
    output logic             no_mem_err,
    output logic             done
);

    localparam int DLL_W = $clog2(DLL_WAIT_CLKS + 1);
    localparam int CNT_W = (DLL_W > GAP_W) ? DLL_W : GAP_W;

    seq_state_e       state_q, state_d;
    logic [1:0]       present;
    logic [1:0]       present_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    ddr_slot_decode #(
        .NUM_SLOTS (2)
    ) u_decode (
        .psz_codes ({slot1_psz, slot0_psz}),
        .present   (present)
    );

    ddr_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // state register and slot capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            present_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                present_q <= present;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = (present == 2'b00) ? S_NOMEM : S_CKE_ON;
                end
            end
            S_NOMEM:     if (!start) state_d = S_IDLE;
            S_CKE_ON:    state_d = S_PRE_A_SET;
            S_PRE_A_SET: state_d = S_EMRS;
            S_EMRS:      state_d = S_PRE_A_CLR;
            S_PRE_A_CLR: state_d = S_MRS_RST;
            S_MRS_RST:   state_d = S_DLL_WAIT;
            S_DLL_WAIT:  if (tmr_zero) state_d = S_PRE_B_SET;
            S_PRE_B_SET: state_d = S_REF_A;
            S_REF_A:     state_d = S_REF_GAP;
            S_REF_GAP:   if (tmr_zero) state_d = S_REF_B;
            S_REF_B:     state_d = S_MRS_FIN;
            S_MRS_FIN:   state_d = S_DONE;
            S_DONE:      if (!start) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cke_en          = 2'b00;
        force_pre       = 1'b0;
        cmd_emrs        = 1'b0;
        cmd_mrs_dll_rst = 1'b0;
        cmd_mrs_final   = 1'b0;
        cmd_refresh     = 1'b0;
        no_mem_err      = 1'b0;
        done            = 1'b0;
        tmr_load        = 1'b0;
        tmr_val         = '0;
        unique case (state_q)
            S_IDLE:  ;
            S_NOMEM: no_mem_err = 1'b1;
            S_CKE_ON: cke_en = 2'b11;
            S_PRE_A_SET: begin
                cke_en    = 2'b11;
                force_pre = 1'b1;
            end
            S_EMRS: begin
                cke_en    = 2'b11;
                force_pre = 1'b1;
                cmd_emrs  = 1'b1;
            end
            S_PRE_A_CLR: cke_en = 2'b11;
            S_MRS_RST: begin
                cke_en          = 2'b11;
                cmd_mrs_dll_rst = 1'b1;
                tmr_load        = 1'b1;
                tmr_val         = CNT_W'(DLL_WAIT_CLKS);
            end
            S_DLL_WAIT: cke_en = 2'b11;
            S_PRE_B_SET: begin
                cke_en    = 2'b11;
                force_pre = 1'b1;
            end
            S_REF_A: begin
                cke_en      = 2'b11;
                force_pre   = 1'b1;
                cmd_refresh = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(ref_gap);
            end
            S_REF_GAP: cke_en = 2'b11;
            S_REF_B: begin
                cke_en      = 2'b11;
                cmd_refresh = 1'b1;
            end
            S_MRS_FIN: begin
                cke_en        = 2'b11;
                cmd_mrs_final = 1'b1;
            end
            S_DONE: begin
                cke_en = {present_q[1], 1'b1};
                done   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] cke_en,
    input logic       force_pre,
    input logic       cmd_emrs,
    input logic       cmd_mrs_dll_rst,
    input logic       cmd_mrs_final,
    input logic       cmd_refresh,
    input logic       no_mem_err,
    input logic       done
);

    logic any_cmd;
    assign any_cmd = cmd_emrs | cmd_mrs_dll_rst | cmd_mrs_final | cmd_refresh;

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_emrs, cmd_mrs_dll_rst, cmd_mrs_final, cmd_refresh}));

    // R5
    emrs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_emrs |=> !cmd_emrs);

    // R5
    refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_refresh |=> !cmd_refresh);

    // R4
    emrs_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_emrs |-> force_pre);

    // R4
    mrs_nopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mrs_dll_rst || cmd_mrs_final) |-> !force_pre);

    // R2
    nomem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_mem_err |-> (cke_en == 2'b00 && !any_cmd && !done));

    // R8
    cke_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |-> (cke_en == 2'b11));

    // R9
    done_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mrs_final |=> done);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> done);

    // R10
    done_cke0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cke_en[0]);

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .cke_en          (cke_en),
    .force_pre       (force_pre),
    .cmd_emrs        (cmd_emrs),
    .cmd_mrs_dll_rst (cmd_mrs_dll_rst),
    .cmd_mrs_final   (cmd_mrs_final),
    .cmd_refresh     (cmd_refresh),
    .no_mem_err      (no_mem_err),
    .done            (done)
);

// File: tb/tb_ddr_pwrup_seq.sv
module tb_ddr_pwrup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DLL_CLKS   = 200;
    localparam int GAP_W      = 8;
    localparam int NVEC       = 6;
    // psz0, psz1, ref_gap, expect_err, expect_cke1_at_done
    localparam int VEC [NVEC][5] = '{
        '{2, 3,   4, 0, 1},
        '{7, 1,   0, 0, 1},
        '{5, 7,  10, 0, 0},
        '{7, 7,   3, 1, 0},
        '{0, 0, 255, 0, 1},
        '{6, 7,   1, 0, 0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       slot0_psz = 3'd0;
    logic [2:0]       slot1_psz = 3'd0;
    logic [GAP_W-1:0] ref_gap = '0;
    logic [1:0]       cke_en;
    logic             force_pre;
    logic             cmd_emrs;
    logic             cmd_mrs_dll_rst;
    logic             cmd_mrs_final;
    logic             cmd_refresh;
    logic             no_mem_err;
    logic             done;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_pwrup_seq #(
        .DLL_WAIT_CLKS (DLL_CLKS),
        .GAP_W         (GAP_W)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .slot0_psz       (slot0_psz),
        .slot1_psz       (slot1_psz),
        .ref_gap         (ref_gap),
        .cke_en          (cke_en),
        .force_pre       (force_pre),
        .cmd_emrs        (cmd_emrs),
        .cmd_mrs_dll_rst (cmd_mrs_dll_rst),
        .cmd_mrs_final   (cmd_mrs_final),
        .cmd_refresh     (cmd_refresh),
        .no_mem_err      (no_mem_err),
        .done            (done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000) begin
            fails++;
            tests++;
            $display("FAIL R3 watchdog: actual hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int outs_all();
        return int'(cke_en) + int'(force_pre) + int'(cmd_emrs) + int'(cmd_mrs_dll_rst)
             + int'(cmd_mrs_final) + int'(cmd_refresh) + int'(no_mem_err) + int'(done);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_case(input int p0, input int p1, input int g, input int ee, input int ec1);
        int c_emrs = -1, c_mrs = -1, c_r1 = -1, c_r2 = -1, c_fin = -1, c_done = -1;
        int n_emrs = 0, n_mrs = 0, n_ref = 0, n_fin = 0;
        int fp_prev = 0, fp_pre_emrs = 0, fp_emrs = 0, fp_r1 = 0, fp_r2 = 1, fp_mrs = 1, fp_fin = 1;
        int cke_bad = 0, err_seen = 0, err_cyc = -1, cke_err = -1, cke_done = -1;
        @(negedge clk);
        slot0_psz = p0[2:0];
        slot1_psz = p1[2:0];
        ref_gap   = g[GAP_W-1:0];
        start     = 1'b1;
        for (int c = 1; c <= 600; c++) begin
            tick();
            if (no_mem_err) begin
                err_seen = 1; err_cyc = c; cke_err = int'(cke_en);
                break;
            end
            if (cmd_emrs) begin
                n_emrs++; c_emrs = c; fp_emrs = int'(force_pre); fp_pre_emrs = fp_prev;
            end
            if (cmd_mrs_dll_rst) begin
                n_mrs++; c_mrs = c; fp_mrs = int'(force_pre);
            end
            if (cmd_refresh) begin
                if (n_ref == 0) begin c_r1 = c; fp_r1 = int'(force_pre); end
                else begin c_r2 = c; fp_r2 = int'(force_pre); end
                n_ref++;
            end
            if (cmd_mrs_final) begin
                n_fin++; c_fin = c; fp_fin = int'(force_pre);
            end
            if (done) begin
                c_done = c; cke_done = int'(cke_en);
                break;
            end
            if (cke_en !== 2'b11) cke_bad++;
            fp_prev = int'(force_pre);
        end
        chk("R2 error flag", err_seen, ee);
        if (ee != 0) begin
            chk("R2 error cycle", err_cyc, 1);
            chk("R2 cke during error", cke_err, 0);
            chk("R2 no strobes", n_emrs + n_mrs + n_ref + n_fin, 0);
            for (int k = 0; k < 3; k++) begin
                tick();
                chk("R2 error held", int'(no_mem_err), 1);
            end
            start = 1'b0;
            tick();
            chk("R2 error cleared", int'(no_mem_err), 0);
        end else begin
            chk("R3 emrs count", n_emrs, 1);
            chk("R3 mrs reset count", n_mrs, 1);
            chk("R3 refresh count", n_ref, 2);
            chk("R3 final mrs count", n_fin, 1);
            chk("R3 emrs cycle", c_emrs, 3);
            chk("R3 mrs reset cycle", c_mrs, 5);
            chk("R3 final after second refresh", c_fin - c_r2, 1);
            chk("R4 pre before emrs", fp_pre_emrs, 1);
            chk("R4 pre at emrs", fp_emrs, 1);
            chk("R4 pre at refresh 1", fp_r1, 1);
            chk("R4 pre at refresh 2", fp_r2, 0);
            chk("R4 pre at mrs reset", fp_mrs, 0);
            chk("R4 pre at final mrs", fp_fin, 0);
            chk("R6 dll wait", c_r1 - c_mrs, DLL_CLKS + 3);
            chk("R7 refresh gap", c_r2 - c_r1, g + 2);
            chk("R8 cke during run", cke_bad, 0);
            chk("R9 done cycle", c_done - c_fin, 1);
            chk("R10 cke at done", cke_done, (ec1 << 1) | 1);
            for (int k = 0; k < 4; k++) begin
                tick();
                chk("R9 done held", int'(done), 1);
            end
            start = 1'b0;
            tick();
            chk("R9 done cleared", int'(done), 0);
            chk("R9 cke cleared", int'(cke_en), 0);
        end
        tick();
    endtask

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2);
        @(negedge clk);
        chk("R1 outputs in reset", outs_all(), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R1 idle without start", outs_all(), 0);
        end

        for (int v = 0; v < NVEC; v++) begin
            run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
        end

        // R10: back-to-back run after an error, slot 1 empty
        run_case(7, 7, 2, 1, 0);
        run_case(4, 7, 2, 0, 0);

        // R1: reset in the middle of a run returns to quiet outputs
        @(negedge clk);
        slot0_psz = 3'd1; slot1_psz = 3'd1; ref_gap = 8'd5; start = 1'b1;
        for (int k = 0; k < 20; k++) tick();
        rst_n = 1'b0;
        start = 1'b0;
        #1;
        chk("R1 outputs after mid-run reset", outs_all(), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 idle after mid-run reset", outs_all(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule